// File: doc/BRIEF.md
# Raster Event Status Pair

This block sits next to a character-based raster timing generator and turns its live counter values into two 8-bit status bytes. Every cycle it compares the horizontal character count, the scanline count and the character row count against the programmed timing values (horizontal total, displayed width, sync position and width, vertical total, displayed rows, vertical sync row, last scanline). Each defined bit of a byte flags that the raster is at one particular position. Most of these flags are active-low. Constant bits help software tell this variant apart. A slow toggle bit changes state once every sixteen frames.

Byte A carries horizontal events. Byte B carries end-of-line, end-of-screen, end-of-display and pre-vertical-sync events, plus the frame toggle. Software reads byte A through register index 10 and byte B through index 11. `rd_sel` picks the byte, and a strobe latches it into `rd_data`. The counters themselves come from the neighbouring generator.

The toggle uses a two-state machine. FT_LOW drives the toggle bit to 0 and FT_HIGH drives it to 1. A frame counter counts `frame_start` pulses. On the pulse that completes a group of sixteen, the machine moves FT_LOW to FT_HIGH or FT_HIGH to FT_LOW, and the counter returns to zero. Reset enters FT_LOW with the counter at zero.

Top module: `raster_event_status`

## Requirements
- R1: Byte A bit 0 is 1 exactly when the character count equals the horizontal total, and 0 otherwise.
- R2: Byte A bit 1 is 0 exactly when the character count equals the horizontal total shifted right by one (rounded down), and 1 otherwise.
- R3: Byte A bit 2 is 0 exactly when the horizontal total is greater than or equal to the displayed width and the character count equals (displayed width − 1) modulo 256. Otherwise it is 1.
- R4: Byte A bit 3 is 0 exactly when the character count equals the sync position. Byte A bit 4 is 0 exactly when the character count equals (sync position + sync width) modulo 256. Both are 1 otherwise.
- R5: Fixed bits hold on every cycle:
  - Byte A bit 6 reads 1, and A bits 5 and 7 read 0.
  - Byte B bit 4 reads 1, and B bits 5 and 6 read 0.
- R6: Byte B bit 0 is 0 exactly when all of these hold, and 1 otherwise:
  - the row count equals the vertical total;
  - the scanline equals the last scanline;
  - the character count equals the horizontal total.
- R7: Byte B bit 1 is 0 exactly when the row count equals (displayed rows − 1) modulo 128, the scanline equals the last scanline and the character count equals the horizontal total. Otherwise it is 1.
- R8: Byte B bit 2 is 0 exactly when the row count equals (vertical sync row − 1) modulo 128, the scanline equals the last scanline and the character count equals the horizontal total. Otherwise it is 1.
- R9: Byte B bit 7 is 1 in either of two cases, and 0 otherwise:
  - the scanline equals the last scanline and the character count equals the horizontal total;
  - the scanline is 0 and the character count is below the horizontal total.
- R10: Byte B bit 3 is 0 after reset. It inverts on every sixteenth `frame_start` pulse, counted from reset.
- R11: `rd_data` is 0 after reset. In the cycle after a clock edge with `rd_stb` high, it holds the byte that was live at that edge: byte A when `rd_sel` is 0, byte B when `rd_sel` is 1. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at each frame start |
| char_cnt | input | 8 | Live horizontal character count |
| row_cnt | input | 7 | Live character row count |
| scan_cnt | input | 5 | Live scanline within the row |
| h_total | input | 8 | Programmed horizontal total (last character index) |
| h_disp | input | 8 | Programmed displayed width in characters |
| hs_pos | input | 8 | Programmed horizontal sync position |
| hs_width | input | 4 | Programmed horizontal sync width |
| v_total | input | 7 | Programmed vertical total (last row index) |
| v_disp | input | 7 | Programmed displayed rows |
| vs_pos | input | 7 | Programmed vertical sync row |
| max_scan | input | 5 | Programmed last scanline of a row |
| rd_stb | input | 1 | Read strobe |
| rd_sel | input | 1 | 0 selects byte A (index 10), 1 selects byte B (index 11) |
| stat_a | output | 8 | Live byte A |
| stat_b | output | 8 | Live byte B |
| rd_data | output | 8 | Byte latched at the last read strobe |

## Verification
Some properties are checked on every cycle:
- The end-of-screen, end-of-display and pre-sync flags in byte B agree with the horizontal-total flag in byte A and with the line-edge bit.
- The frame counter stays in range.
- The toggle state moves only on a frame pulse that completes a group.
- The read register changes only on a strobe, and then to the selected live byte.

The exact positions of each active-low flag need the bench's scenarios. So do the modulo wrap of "minus one" and "plus width", the displayed-width guard, the sixteen-frame period and the fixed bits.

// File: rtl/raster_stat_pkg.sv
package raster_stat_pkg;

    localparam int STAT_W = 8;

    // byte A bit positions (software decodes these)
    localparam int A_HTOT    = 0;
    localparam int A_HHALF   = 1;
    localparam int A_HDISPM1 = 2;
    localparam int A_HSPOS   = 3;
    localparam int A_HSEND   = 4;
    localparam int A_ONE     = 6;

    // byte B bit positions; the three row events occupy bits 0..2 in order
    localparam int B_ROWEV0   = 0;
    localparam int B_NROWEV   = 3;
    localparam int B_TOGGLE   = 3;
    localparam int B_ONE      = 4;
    localparam int B_LINEEDGE = 7;

    typedef enum logic {
        FT_LOW  = 1'b0,
        FT_HIGH = 1'b1
    } ftmr_state_e;

endpackage

// File: rtl/hstat_cmp.sv
module hstat_cmp
    import raster_stat_pkg::*;
#(
    parameter int HW = 8,
    parameter int WW = 4
) (
    input  logic [HW-1:0]     char_cnt,
    input  logic [HW-1:0]     h_total,
    input  logic [HW-1:0]     h_disp,
    input  logic [HW-1:0]     hs_pos,
    input  logic [WW-1:0]     hs_width,
    output logic [STAT_W-1:0] stat_a
);

    logic [HW-1:0] disp_m1;
    logic [HW-1:0] hs_end;
    logic [HW-1:0] half_tot;

    always_comb begin
        disp_m1  = h_disp - 1'b1;
        hs_end   = hs_pos + HW'(hs_width);
        half_tot = h_total >> 1;
    end

    always_comb begin
        stat_a            = '0;
        stat_a[A_HTOT]    = (char_cnt == h_total);
        stat_a[A_HHALF]   = (char_cnt != half_tot);
        stat_a[A_HDISPM1] = !((h_total >= h_disp) && (char_cnt == disp_m1));
        stat_a[A_HSPOS]   = (char_cnt != hs_pos);
        stat_a[A_HSEND]   = (char_cnt != hs_end);
        stat_a[A_ONE]     = 1'b1;
    end

endmodule

// File: rtl/vstat_cmp.sv
module vstat_cmp
    import raster_stat_pkg::*;
#(
    parameter int HW = 8,
    parameter int RW = 7,
    parameter int SW = 5
) (
    input  logic [HW-1:0]     char_cnt,
    input  logic [HW-1:0]     h_total,
    input  logic [RW-1:0]     row_cnt,
    input  logic [SW-1:0]     scan_cnt,
    input  logic [RW-1:0]     v_total,
    input  logic [RW-1:0]     v_disp,
    input  logic [RW-1:0]     vs_pos,
    input  logic [SW-1:0]     max_scan,
    input  logic              toggle,
    output logic [STAT_W-1:0] stat_b
);

    logic              line_end;
    logic [RW-1:0]     row_tgt [B_NROWEV];
    logic [B_NROWEV-1:0] row_hit;

    always_comb begin
        line_end   = (scan_cnt == max_scan) && (char_cnt == h_total);
        row_tgt[0] = v_total;
        row_tgt[1] = v_disp - 1'b1;
        row_tgt[2] = vs_pos - 1'b1;
    end

    for (genvar i = 0; i < B_NROWEV; i++) begin : g_row
        assign row_hit[i] = line_end && (row_cnt == row_tgt[i]);
    end

    always_comb begin
        stat_b = '0;
        for (int i = 0; i < B_NROWEV; i++) begin
            stat_b[B_ROWEV0 + i] = !row_hit[i];
        end
        stat_b[B_TOGGLE]   = toggle;
        stat_b[B_ONE]      = 1'b1;
        stat_b[B_LINEEDGE] = line_end || ((scan_cnt == '0) && (char_cnt < h_total));
    end

endmodule

// File: rtl/frame_toggle.sv
module frame_toggle
    import raster_stat_pkg::*;
#(
    parameter int FRAMES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    output logic toggle
);

    localparam int CW = (FRAMES > 1) ? $clog2(FRAMES) : 1;
    localparam logic [CW-1:0] LAST = CW'(FRAMES - 1);

    ftmr_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FT_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        wrap    = (cnt_q == LAST);
        state_d = state_q;
        cnt_d   = cnt_q;
        if (frame_start) begin
            cnt_d = wrap ? '0 : cnt_q + 1'b1;
        end
        unique case (state_q)
            FT_LOW:  if (frame_start && wrap) state_d = FT_HIGH;
            FT_HIGH: if (frame_start && wrap) state_d = FT_LOW;
        endcase
    end

    assign toggle = (state_q == FT_HIGH);

    assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    assert_flip_on_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && cnt_q == LAST) |=> (toggle != $past(toggle)));

    assert_hold_no_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(toggle) && $stable(cnt_q)));

endmodule

// File: rtl/raster_event_status.sv
module raster_event_status
    import raster_stat_pkg::*;
#(
    parameter int CHAR_W        = 8,
    parameter int ROW_W         = 7,
    parameter int SCAN_W        = 5,
    parameter int HSW_W         = 4,
    parameter int TOGGLE_FRAMES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [CHAR_W-1:0] char_cnt,
    input  logic [ROW_W-1:0]  row_cnt,
    input  logic [SCAN_W-1:0] scan_cnt,
    input  logic [CHAR_W-1:0] h_total,
    input  logic [CHAR_W-1:0] h_disp,
    input  logic [CHAR_W-1:0] hs_pos,
    input  logic [HSW_W-1:0]  hs_width,
    input  logic [ROW_W-1:0]  v_total,
    input  logic [ROW_W-1:0]  v_disp,
    input  logic [ROW_W-1:0]  vs_pos,
    input  logic [SCAN_W-1:0] max_scan,
    input  logic              rd_stb,
    input  logic              rd_sel,
    output logic [7:0]        stat_a,
    output logic [7:0]        stat_b,
    output logic [7:0]        rd_data
);

    logic toggle;

    frame_toggle #(.FRAMES(TOGGLE_FRAMES)) u_toggle (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .toggle      (toggle)
    );

    hstat_cmp #(.HW(CHAR_W), .WW(HSW_W)) u_hcmp (
        .char_cnt (char_cnt),
        .h_total  (h_total),
        .h_disp   (h_disp),
        .hs_pos   (hs_pos),
        .hs_width (hs_width),
        .stat_a   (stat_a)
    );

    vstat_cmp #(.HW(CHAR_W), .RW(ROW_W), .SW(SCAN_W)) u_vcmp (
        .char_cnt (char_cnt),
        .h_total  (h_total),
        .row_cnt  (row_cnt),
        .scan_cnt (scan_cnt),
        .v_total  (v_total),
        .v_disp   (v_disp),
        .vs_pos   (vs_pos),
        .max_scan (max_scan),
        .toggle   (toggle),
        .stat_b   (stat_b)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_stb) begin
            rd_data <= rd_sel ? stat_b : stat_a;
        end
    end

    assert_last_screen_hmatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_b[B_ROWEV0] |-> (stat_a[A_HTOT] && stat_b[B_LINEEDGE]));

    assert_last_disp_hmatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_b[B_ROWEV0 + 1] |-> (stat_a[A_HTOT] && stat_b[B_LINEEDGE]));

    assert_pre_vsync_hmatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_b[B_ROWEV0 + 2] |-> (stat_a[A_HTOT] && stat_b[B_LINEEDGE]));

    assert_read_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

    assert_read_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (rd_data == ($past(rd_sel) ? $past(stat_b) : $past(stat_a))));

endmodule

// File: tb/raster_event_status_test.sv
module raster_event_status_test;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic [7:0] char_cnt = '0;
    logic [6:0] row_cnt = '0;
    logic [4:0] scan_cnt = '0;
    logic [7:0] h_total = 8'd63, h_disp = 8'd40, hs_pos = 8'd46;
    logic [3:0] hs_width = 4'd14;
    logic [6:0] v_total = 7'd38, v_disp = 7'd25, vs_pos = 7'd30;
    logic [4:0] max_scan = 5'd7;
    logic       rd_stb = 1'b0, rd_sel = 1'b0;
    logic [7:0] stat_a, stat_b, rd_data;

    raster_event_status uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .char_cnt(char_cnt), .row_cnt(row_cnt), .scan_cnt(scan_cnt),
        .h_total(h_total), .h_disp(h_disp), .hs_pos(hs_pos), .hs_width(hs_width),
        .v_total(v_total), .v_disp(v_disp), .vs_pos(vs_pos), .max_scan(max_scan),
        .rd_stb(rd_stb), .rd_sel(rd_sel),
        .stat_a(stat_a), .stat_b(stat_b), .rd_data(rd_data)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    int         m_frames = 0;
    logic       m_tmr    = 1'b0;
    logic [7:0] m_rd     = 8'h00;

    function automatic logic [7:0] ref_a();
        int h = int'(char_cnt);
        int t = int'(h_total);
        int d = int'(h_disp);
        int p = int'(hs_pos);
        int w = int'(hs_width);
        logic [7:0] r = 8'h00;
        r[0] = (h == t);
        r[1] = (h != t / 2);
        r[2] = !((t >= d) && (h == (d + 255) % 256));
        r[3] = (h != p);
        r[4] = (h != (p + w) % 256);
        r[6] = 1'b1;
        return r;
    endfunction

    function automatic logic [7:0] ref_b(input logic tb);
        int  h  = int'(char_cnt);
        int  t  = int'(h_total);
        int  rw = int'(row_cnt);
        bit  le = (scan_cnt == max_scan) && (h == t);
        logic [7:0] r = 8'h00;
        r[0] = !(le && rw == int'(v_total));
        r[1] = !(le && rw == (int'(v_disp) + 127) % 128);
        r[2] = !(le && rw == (int'(vs_pos) + 127) % 128);
        r[3] = tb;
        r[4] = 1'b1;
        r[7] = le || (scan_cnt == 0 && h < t);
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_frames = 0;
            m_tmr    = 1'b0;
            m_rd     = 8'h00;
        end else begin
            if (rd_stb) m_rd = rd_sel ? ref_b(m_tmr) : ref_a();
            if (frame_start) begin
                m_frames++;
                if (m_frames == 16) begin
                    m_frames = 0;
                    m_tmr    = ~m_tmr;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            logic [7:0] ea, eb;
            ea = ref_a();
            eb = ref_b(m_tmr);
            chk("R1 htotal match",     {7'd0, stat_a[0]},   {7'd0, ea[0]});
            chk("R2 half total",       {7'd0, stat_a[1]},   {7'd0, ea[1]});
            chk("R3 displayed-1",      {7'd0, stat_a[2]},   {7'd0, ea[2]});
            chk("R4 sync pos/end",     {6'd0, stat_a[4:3]}, {6'd0, ea[4:3]});
            chk("R5 fixed bits",       {2'd0, stat_a[7:5], stat_b[6:4]},
                                       {2'd0, ea[7:5], eb[6:4]});
            chk("R6 last of screen",   {7'd0, stat_b[0]},   {7'd0, eb[0]});
            chk("R7 last displayed",   {7'd0, stat_b[1]},   {7'd0, eb[1]});
            chk("R8 before vsync",     {7'd0, stat_b[2]},   {7'd0, eb[2]});
            chk("R9 line edge",        {7'd0, stat_b[7]},   {7'd0, eb[7]});
            chk("R10 frame toggle",    {7'd0, stat_b[3]},   {7'd0, m_tmr});
            chk("R11 read latch",      rd_data,             m_rd);
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic defaults();
        h_total = 8'd63; h_disp = 8'd40; hs_pos = 8'd46; hs_width = 4'd14;
        v_total = 7'd38; v_disp = 7'd25; vs_pos = 7'd30; max_scan = 5'd7;
    endtask

    task automatic sweep_row(input logic [6:0] rw, input logic [4:0] sc);
        row_cnt  = rw;
        scan_cnt = sc;
        for (int h = 0; h < 72; h++) begin
            char_cnt = 8'(h);
            rd_stb   = (h % 3 == 0);
            rd_sel   = (h % 2 == 1);
            tick();
        end
        rd_stb = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL R11 watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // reset state (R11 rd_data 0, R10 toggle 0)
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // typical timing, sweep across each row event (R1..R9)
        sweep_row(7'd38, 5'd7);
        sweep_row(7'd24, 5'd7);
        sweep_row(7'd29, 5'd7);
        sweep_row(7'd0,  5'd0);
        sweep_row(7'd5,  5'd3);

        // corner: displayed width 0 wraps to 255 (R3)
        h_disp = 8'd0;
        char_cnt = 8'd255; tick();
        char_cnt = 8'd254; tick();
        // corner: displayed width beyond total disables the event (R3)
        h_disp = 8'd70;
        char_cnt = 8'd69; tick();
        // corner: sync end wraps modulo 256 (R4)
        hs_pos = 8'd250; hs_width = 4'd10;
        char_cnt = 8'd4; tick();
        char_cnt = 8'd250; tick();
        // corner: displayed rows / sync row 0 wrap to row 127 (R7, R8)
        defaults();
        v_disp = 7'd0; vs_pos = 7'd0;
        row_cnt = 7'd127; scan_cnt = 5'd7; char_cnt = 8'd63;
        rd_stb = 1'b1; rd_sel = 1'b1; tick();
        rd_stb = 1'b0; tick();
        // corner: total 0, single scanline row (R1, R2, R9)
        h_total = 8'd0; max_scan = 5'd0; scan_cnt = 5'd0; char_cnt = 8'd0; tick();
        char_cnt = 8'd1; tick();
        defaults();

        // frame toggle over 40 frames, reading byte B each time (R10, R11)
        row_cnt = 7'd3; scan_cnt = 5'd2; char_cnt = 8'd10;
        for (int f = 0; f < 40; f++) begin
            frame_start = 1'b1; rd_stb = 1'b1; rd_sel = 1'b1;
            tick();
            frame_start = 1'b0; rd_stb = 1'b0;
            tick();
            tick();
        end

        // mid-run reset returns toggle and read register to 0 (R10, R11)
        rst_n = 1'b0; tick(); tick();
        rst_n = 1'b1; tick();

        // dense random stimulus in small ranges so matches are frequent
        for (int n = 0; n < 4000; n++) begin
            h_total     = 8'($urandom_range(0, 15));
            h_disp      = 8'($urandom_range(0, 18));
            hs_pos      = 8'($urandom_range(0, 15));
            hs_width    = 4'($urandom_range(0, 15));
            char_cnt    = 8'($urandom_range(0, 31));
            v_total     = 7'($urandom_range(0, 7));
            v_disp      = 7'($urandom_range(0, 8));
            vs_pos      = 7'($urandom_range(0, 8));
            row_cnt     = 7'($urandom_range(0, 7));
            max_scan    = 5'($urandom_range(0, 3));
            scan_cnt    = 5'($urandom_range(0, 3));
            frame_start = ($urandom_range(0, 3) == 0);
            rd_stb      = ($urandom_range(0, 1) == 1);
            rd_sel      = ($urandom_range(0, 1) == 1);
            tick();
        end
        frame_start = 1'b0;
        rd_stb = 1'b0;
        tick();

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule